// File: doc/BRIEF.md
# Configurable Bidirectional Pad Cell

This block is the logic side of one general-purpose pad. It takes an output value from the internal logic and drives a single tri-state pin. It also returns the level seen on that pin to the internal routing, so any logic block can consume it. A set of static configuration inputs sets up the cell. They choose among input-only, output-only and bidirectional operation. They pick a push-pull or a low-side-only output stage. They choose whether the driver enable comes from a chip-wide enable or from a per-block enable term. They also choose which of two data sources feeds the pin.

The cell is purely combinational. Configuration is expected to be held constant while the cell is in use. With every configuration bit at zero, the cell is a bidirectional, push-pull pin. In that state it is enabled by the chip-wide enable and fed from the routed data source. The actual driver enable and driven value are exposed as separate outputs, so a pin's state can be observed without resolving the pad net.

Top module: `iocell_top`

## Requirements
- R1: With all configuration inputs at zero, the cell is bidirectional (cfg_mode_i = 2'b00), push-pull (cfg_od_i = 0), enabled by the global enable (cfg_oe_pt_i = 0) and fed from data_route_i (cfg_bypass_i = 0).
- R2: In bidirectional mode with cfg_oe_pt_i = 0, the driver is enabled exactly when the active-low goe_ni is 0, and pt_oe_i has no effect.
- R3: In bidirectional mode with cfg_oe_pt_i = 1, the driver is enabled exactly when pt_oe_i is 1, and goe_ni has no effect.
- R4: In output mode (cfg_mode_i = 2'b01), the output stage is enabled whatever goe_ni and pt_oe_i are.
- R5: In input mode (cfg_mode_i = 2'b10 or 2'b11), drv_en_o stays 0 and the pin is never driven, whatever the enables and data are.
- R6: In push-pull style, while enabled, the pin is driven to the selected data value at both levels (drv_val_o equals the data).
- R7: In open-drain style (cfg_od_i = 1), while enabled, the pin is driven low when the data is 0 and released (drv_en_o = 0, pin high-impedance) when the data is 1, and drv_val_o is never 1 while drv_en_o is 1.
- R8: cfg_bypass_i = 0 selects data_route_i and cfg_bypass_i = 1 selects data_byp_i as the output data; the unselected source has no effect on the pin.
- R9: in_o always equals the resolved pin level: the value the cell drives, an external driver's value when released, or the external pull-up level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_mode_i | input | 2 | Usage: 00 bidirectional, 01 output, 10/11 input |
| cfg_od_i | input | 1 | 0 push-pull, 1 open-drain |
| cfg_oe_pt_i | input | 1 | 0 global enable, 1 product-term enable |
| cfg_bypass_i | input | 1 | 0 routed data, 1 bypass data |
| goe_ni | input | 1 | Chip-wide output enable, active low |
| pt_oe_i | input | 1 | Per-block output enable term, active high |
| data_route_i | input | 1 | Output data through the routing path |
| data_byp_i | input | 1 | Output data through the direct bypass path |
| pad_io | inout | 1 | Pin |
| in_o | output | 1 | Pin level returned to internal routing |
| drv_en_o | output | 1 | Driver actually enabled onto the pin |
| drv_val_o | output | 1 | Value driven while drv_en_o is 1 |

## Verification
Immediate assertions are evaluated whenever the cell's inputs change. They check that input mode never enables the driver, that open-drain never drives high, and that output mode in push-pull style is always enabled. They also check that a bidirectional push-pull cell on the global enable follows goe_ni, and that the returned value tracks the pin level. Only the bench's scenarios can show two further behaviours. One is that the unselected enable and data sources really have no effect. The other is that a released open-drain pin reads back the external pull-up, or a value forced from outside.

// File: rtl/iocell_pkg.sv
package iocell_pkg;
  typedef enum logic [1:0] {
    MODE_BIDIR  = 2'b00,
    MODE_OUT    = 2'b01,
    MODE_IN     = 2'b10,
    MODE_IN_ALT = 2'b11
  } io_mode_e;
endpackage

// File: rtl/iocell_oe_ctrl.sv
module iocell_oe_ctrl
  import iocell_pkg::*;
#(
  parameter bit GOE_ACTIVE_LOW = 1'b1
) (
  input  io_mode_e mode_i,
  input  logic     sel_pt_i,
  input  logic     goe_i,
  input  logic     pt_oe_i,
  output logic     oe_o
);
  logic goe_on;
  logic sel_oe;

  generate
    if (GOE_ACTIVE_LOW) begin : g_goe_low
      assign goe_on = ~goe_i;
    end else begin : g_goe_high
      assign goe_on = goe_i;
    end
  endgenerate

  assign sel_oe = sel_pt_i ? pt_oe_i : goe_on;

  // mode gates the chosen enable
  always_comb begin
    unique case (mode_i)
      MODE_BIDIR: oe_o = sel_oe;
      MODE_OUT:   oe_o = 1'b1;
      default:    oe_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/iocell_data_sel.sv
module iocell_data_sel (
  input  logic sel_byp_i,
  input  logic route_i,
  input  logic byp_i,
  output logic data_o
);
  assign data_o = sel_byp_i ? byp_i : route_i;
endmodule

// File: rtl/iocell_drv.sv
module iocell_drv (
  input  logic od_i,
  input  logic oe_i,
  input  logic data_i,
  output logic en_o,
  output logic val_o
);
  // open-drain: release on 1, only ever pull low
  assign en_o  = oe_i & (od_i ? ~data_i : 1'b1);
  assign val_o = od_i ? 1'b0 : data_i;
endmodule

// File: rtl/iocell_top.sv
module iocell_top
  import iocell_pkg::*;
#(
  parameter bit GOE_ACTIVE_LOW = 1'b1
) (
  input  logic [1:0] cfg_mode_i,
  input  logic       cfg_od_i,
  input  logic       cfg_oe_pt_i,
  input  logic       cfg_bypass_i,
  input  logic       goe_ni,
  input  logic       pt_oe_i,
  input  logic       data_route_i,
  input  logic       data_byp_i,
  inout  wire        pad_io,
  output logic       in_o,
  output logic       drv_en_o,
  output logic       drv_val_o
);
  io_mode_e mode;
  logic     oe;
  logic     data;

  assign mode = io_mode_e'(cfg_mode_i);

  iocell_oe_ctrl #(
    .GOE_ACTIVE_LOW(GOE_ACTIVE_LOW)
  ) u_oe (
    .mode_i  (mode),
    .sel_pt_i(cfg_oe_pt_i),
    .goe_i   (goe_ni),
    .pt_oe_i (pt_oe_i),
    .oe_o    (oe)
  );

  iocell_data_sel u_data (
    .sel_byp_i(cfg_bypass_i),
    .route_i  (data_route_i),
    .byp_i    (data_byp_i),
    .data_o   (data)
  );

  iocell_drv u_drv (
    .od_i  (cfg_od_i),
    .oe_i  (oe),
    .data_i(data),
    .en_o  (drv_en_o),
    .val_o (drv_val_o)
  );

  assign pad_io = drv_en_o ? drv_val_o : 1'bz;
  assign in_o   = pad_io;

  always_comb begin
    // R5
    a_r5_input_never_drives: assert (!(cfg_mode_i[1] && drv_en_o))
      else $error("input mode drives pin");
    // R7
    a_r7_od_never_high: assert (!(cfg_od_i && drv_en_o && drv_val_o))
      else $error("open-drain drives high");
    // R4
    a_r4_output_enabled: assert (!(cfg_mode_i == 2'b01 && !cfg_od_i) || drv_en_o)
      else $error("output mode not enabled");
    // R2
    a_r2_goe_follow: assert (!(cfg_mode_i == 2'b00 && !cfg_od_i && !cfg_oe_pt_i)
                             || (drv_en_o == (GOE_ACTIVE_LOW ? !goe_ni : goe_ni)))
      else $error("global enable not followed");
    // R9
    a_r9_own_drive_seen: assert (!drv_en_o || (in_o == drv_val_o))
      else $error("returned level differs from driven value");
  end
endmodule

// File: tb/tb_iocell_top.sv
`timescale 1ns/1ps
module tb_iocell_top;
  logic       clk = 1'b0;
  logic [1:0] cfg_mode;
  logic       cfg_od, cfg_oe_pt, cfg_bypass;
  logic       goe_n, pt_oe, d_route, d_byp;
  logic       ext_en, ext_val;
  wire        pad;
  logic       in_w, drv_en, drv_val;
  int         checks = 0;
  int         failures = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  iocell_top dut (
    .cfg_mode_i  (cfg_mode),
    .cfg_od_i    (cfg_od),
    .cfg_oe_pt_i (cfg_oe_pt),
    .cfg_bypass_i(cfg_bypass),
    .goe_ni      (goe_n),
    .pt_oe_i     (pt_oe),
    .data_route_i(d_route),
    .data_byp_i  (d_byp),
    .pad_io      (pad),
    .in_o        (in_w),
    .drv_en_o    (drv_en),
    .drv_val_o   (drv_val)
  );

  // external driver and pull-up
  assign pad = ext_en ? ext_val : 1'bz;
  assign pad = (!drv_en && !ext_en) ? 1'b1 : 1'bz;

  task automatic setup(input logic [1:0] m, input logic od, input logic ptsel,
                       input logic byp, input logic g, input logic p,
                       input logic dr, input logic db);
    @(posedge clk);
    cfg_mode = m; cfg_od = od; cfg_oe_pt = ptsel; cfg_bypass = byp;
    goe_n = g; pt_oe = p; d_route = dr; d_byp = db;
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic en_e, input logic val_e,
                     input logic in_e);
    checks++;
    if (drv_en !== en_e || (en_e && drv_val !== val_e) || in_w !== in_e) begin
      failures++;
      $display("FAIL %s: en=%b val=%b in=%b expected en=%b val=%b in=%b",
               req, drv_en, drv_val, in_w, en_e, val_e, in_e);
    end
  endtask

  task automatic t_default;
    setup(2'b00, 0, 0, 0, 0, 0, 1, 0);
    chk("R1", 1, 1, 1);
    setup(2'b00, 0, 0, 0, 0, 0, 0, 1);
    chk("R1", 1, 0, 0);
  endtask

  task automatic t_bidir_global;
    setup(2'b00, 0, 0, 0, 1, 1, 0, 0);
    chk("R2", 0, 0, 1);
    setup(2'b00, 0, 0, 0, 0, 0, 0, 0);
    chk("R2", 1, 0, 0);
  endtask

  task automatic t_bidir_pt;
    setup(2'b00, 0, 1, 0, 0, 0, 0, 0);
    chk("R3", 0, 0, 1);
    setup(2'b00, 0, 1, 0, 1, 1, 0, 0);
    chk("R3", 1, 0, 0);
  endtask

  task automatic t_output_mode;
    for (int k = 0; k < 4; k++) begin
      setup(2'b01, 0, k[0], 0, k[1], k[0], 0, 0);
      chk("R4", 1, 0, 0);
    end
  endtask

  task automatic t_input_mode;
    for (int k = 0; k < 4; k++) begin
      setup(k[0] ? 2'b11 : 2'b10, 0, k[1], 0, 0, 1, 0, 0);
      chk("R5", 0, 0, 1);
    end
  endtask

  task automatic t_push_pull;
    setup(2'b01, 0, 0, 0, 1, 0, 1, 0);
    chk("R6", 1, 1, 1);
    setup(2'b01, 0, 0, 0, 1, 0, 0, 1);
    chk("R6", 1, 0, 0);
  endtask

  task automatic t_open_drain;
    setup(2'b01, 1, 0, 0, 1, 0, 0, 0);
    chk("R7", 1, 0, 0);
    setup(2'b01, 1, 0, 0, 1, 0, 1, 0);
    chk("R7", 0, 0, 1);
    setup(2'b00, 1, 1, 0, 0, 0, 0, 0);
    chk("R7", 0, 0, 1);
  endtask

  task automatic t_bypass;
    setup(2'b01, 0, 0, 1, 1, 0, 0, 1);
    chk("R8", 1, 1, 1);
    setup(2'b01, 0, 0, 1, 1, 0, 1, 0);
    chk("R8", 1, 0, 0);
    setup(2'b01, 0, 0, 0, 1, 0, 1, 0);
    chk("R8", 1, 1, 1);
  endtask

  task automatic t_readback;
    setup(2'b10, 0, 0, 0, 0, 0, 1, 1);
    @(posedge clk); ext_en = 1; ext_val = 0;
    @(negedge clk);
    chk("R9", 0, 0, 0);
    setup(2'b01, 1, 0, 0, 0, 0, 1, 0);
    @(negedge clk);
    chk("R9", 0, 0, 0);
    @(posedge clk); ext_val = 1;
    @(negedge clk);
    chk("R9", 0, 0, 1);
    @(posedge clk); ext_en = 0;
    @(negedge clk);
    chk("R9", 0, 0, 1);
  endtask

  initial begin
    cfg_mode = 2'b00; cfg_od = 0; cfg_oe_pt = 0; cfg_bypass = 0;
    goe_n = 1; pt_oe = 0; d_route = 0; d_byp = 0;
    ext_en = 0; ext_val = 0;
    repeat (3) @(posedge clk);
    t_default();
    t_bidir_global();
    t_bidir_pt();
    t_output_mode();
    t_input_mode();
    t_push_pull();
    t_open_drain();
    t_bypass();
    t_readback();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: expired, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule